// File: doc/BRIEF.md
# Precedence-Graph Task Dispatcher

This block is the central dispatcher of a many-core fabric. Before a run, a small table of tasks is written through a programming port. Each entry gives an instance count, the number of predecessor tasks that must finish first, a long-task flag and a bit mask of successor tasks. The instances of one task are independent of each other. The dispatcher hands them out as packs: contiguous ranges of instances of a single task, up to `CAPACITY` instances per pack, with at most one pack per cycle.

Completion reports come back from the distribution network. Each report names a task and a number of finished instances. A task releases its successors only when its finished count reaches its instance count. At that point each successor's outstanding-predecessor counter drops by one, and a successor whose counter reaches zero becomes eligible. Flagged (long) tasks are dispatched before unflagged ones. The run ends when every programmed task with an empty successor mask has finished.

The pack output is valid/ready. A pack that has been offered stays offered, unchanged, until the consumer takes it, and the dispatcher allocates no new pack while an offered one is not yet taken. The report input is also valid/ready. Its ready is high for the whole run and low otherwise, so a report offered while no run is active is never accepted.

Top module: `tmsched_top`

## Requirements
- R1: A write on the programming port stores the entry named by `cfg_task` while `busy` is low; a write while `busy` is high is ignored and leaves the instances dispatched in that run unchanged.
- R2: A `start` pulse while `busy` is low reloads every entry's predecessor counter, clears its dispatched and finished counts, raises `busy` on the next cycle and clears `done`.
- R3: Each pack names one task. `pk_first` equals the number of that task's instances already dispatched, and `pk_count` equals the smaller of `CAPACITY` and the instances still undispatched. Over a run, every task dispatches exactly its instance count.
- R4: While `pk_valid` is high and `pk_ready` is low, `pk_valid` stays high and `pk_task`, `pk_first` and `pk_count` hold their values.
- R5: No instance of a task is dispatched until every task whose successor mask has that task's bit set has finished all of its instances.
- R6: A task counts as finished only when the sum of its accepted report counts equals its instance count; partial reports release no successor.
- R7: When several tasks are eligible, a flagged task is chosen before any unflagged one, and among tasks of equal flag the lowest index wins.
- R8: `done` rises and `busy` falls once every programmed task with an all-zero successor mask has finished; `done` is never high while such a task is unfinished, and `done` and `busy` are never high together.
- R9: `tm_ready` equals `busy`; a report is counted only on a cycle where `tm_valid` and `tm_ready` are both high.
- R10: An entry never written since reset is never dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Programming write strobe |
| cfg_task | input | TID_W | Entry index to write |
| cfg_inst | input | INST_W | Instance count of the entry |
| cfg_deps | input | DEP_W | Number of predecessors of the entry |
| cfg_long | input | 1 | Long-task flag, dispatched first |
| cfg_succ | input | NUM_TASKS | Successor mask, bit s set means task s depends on this entry |
| start | input | 1 | Begin a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| pk_valid | output | 1 | Pack offered |
| pk_ready | input | 1 | Consumer takes the pack |
| pk_task | output | TID_W | Task of the pack |
| pk_first | output | INST_W | Index of the first instance in the pack |
| pk_count | output | PACK_W | Instances in the pack |
| tm_valid | input | 1 | Completion report offered |
| tm_ready | output | 1 | Reports accepted |
| tm_task | input | TID_W | Task of the report |
| tm_count | input | PACK_W | Finished instances in the report |

## Verification
A corrupted finished count or predecessor counter shows up as a successor pack that appears before its predecessor's last report, or as a run that never raises `done`. The premature pack is seen about two cycles after the report that wrongly releases it. A wrong dispatched count shows up on the next pack of that task, as a `pk_first` or `pk_count` that differs from the running total kept by the bench. A broken priority choice shows up as an out-of-order pack on the very next handshake when every task stays eligible.

// File: rtl/tmsched_pkg.sv
package tmsched_pkg;
  localparam int unsigned DEF_TASKS = 8;
  localparam int unsigned DEF_INST_W = 10;
  localparam int unsigned DEF_DEP_W = 4;
  localparam int unsigned DEF_CAPACITY = 5;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;
endpackage

// File: rtl/tmsched_entry.sv
module tmsched_entry #(
  parameter int unsigned NUM_TASKS = 8,
  parameter int unsigned INST_W = 10,
  parameter int unsigned DEP_W = 4,
  parameter int unsigned CAPACITY = 5,
  parameter int unsigned ID = 0,
  localparam int unsigned TID_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int unsigned PACK_W = $clog2(CAPACITY + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 start,
  input  logic                 cfg_we,
  input  logic [TID_W-1:0]     cfg_task,
  input  logic [INST_W-1:0]    cfg_inst,
  input  logic [DEP_W-1:0]     cfg_deps,
  input  logic                 cfg_long,
  input  logic [NUM_TASKS-1:0] cfg_succ,
  input  logic                 issue,
  input  logic                 rpt_en,
  input  logic [TID_W-1:0]     rpt_task,
  input  logic [PACK_W-1:0]    rpt_count,
  input  logic [DEP_W-1:0]     dec_n,
  output logic                 eligible,
  output logic                 is_long,
  output logic [INST_W-1:0]    next_first,
  output logic [PACK_W-1:0]    next_count,
  output logic                 release_p,
  output logic [NUM_TASKS-1:0] succ,
  output logic                 terminal_ok
);
  logic              used_q;
  logic [INST_W-1:0] inst_q;
  logic [DEP_W-1:0]  deps_q;
  logic [DEP_W-1:0]  wait_q;
  logic [INST_W-1:0] sent_q;
  logic [INST_W-1:0] fin_q;
  logic              rel_q;
  logic [INST_W-1:0] remain;
  logic              finished;

  assign remain     = inst_q - sent_q;
  assign finished   = used_q && (fin_q == inst_q);
  assign eligible   = run && used_q && (wait_q == '0) && (sent_q != inst_q);
  assign next_first = sent_q;
  assign next_count = (remain > INST_W'(CAPACITY)) ? PACK_W'(CAPACITY) : remain[PACK_W-1:0];
  assign release_p  = run && finished && !rel_q;
  assign terminal_ok = !used_q || (succ != '0) || rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q  <= 1'b0;
      inst_q  <= '0;
      deps_q  <= '0;
      is_long <= 1'b0;
      succ    <= '0;
    end else if (cfg_we && !run && (cfg_task == TID_W'(ID))) begin
      used_q  <= 1'b1;
      inst_q  <= cfg_inst;
      deps_q  <= cfg_deps;
      is_long <= cfg_long;
      succ    <= cfg_succ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      sent_q <= '0;
      fin_q  <= '0;
      rel_q  <= 1'b0;
    end else if (start && !run) begin
      wait_q <= deps_q;
      sent_q <= '0;
      fin_q  <= '0;
      rel_q  <= 1'b0;
    end else if (run) begin
      wait_q <= wait_q - dec_n;
      if (issue) sent_q <= sent_q + INST_W'(next_count);
      if (rpt_en && (rpt_task == TID_W'(ID))) fin_q <= fin_q + INST_W'(rpt_count);
      if (release_p) rel_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tmsched_pick.sv
module tmsched_pick #(
  parameter int unsigned NUM_TASKS = 8,
  localparam int unsigned TID_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic [NUM_TASKS-1:0] elig,
  input  logic [NUM_TASKS-1:0] flag,
  output logic                 any,
  output logic [TID_W-1:0]     idx
);
  logic [NUM_TASKS-1:0] hot;

  assign hot = elig & flag;
  assign any = |elig;

  always_comb begin
    idx = '0;
    for (int t = NUM_TASKS - 1; t >= 0; t--) begin
      if (elig[t]) idx = TID_W'(t);
    end
    if (|hot) begin
      for (int t = NUM_TASKS - 1; t >= 0; t--) begin
        if (hot[t]) idx = TID_W'(t);
      end
    end
  end
endmodule

// File: rtl/tmsched_top.sv
module tmsched_top
  import tmsched_pkg::*;
#(
  parameter int unsigned NUM_TASKS = DEF_TASKS,
  parameter int unsigned INST_W = DEF_INST_W,
  parameter int unsigned DEP_W = DEF_DEP_W,
  parameter int unsigned CAPACITY = DEF_CAPACITY,
  localparam int unsigned TID_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int unsigned PACK_W = $clog2(CAPACITY + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [TID_W-1:0]     cfg_task,
  input  logic [INST_W-1:0]    cfg_inst,
  input  logic [DEP_W-1:0]     cfg_deps,
  input  logic                 cfg_long,
  input  logic [NUM_TASKS-1:0] cfg_succ,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic                 pk_valid,
  input  logic                 pk_ready,
  output logic [TID_W-1:0]     pk_task,
  output logic [INST_W-1:0]    pk_first,
  output logic [PACK_W-1:0]    pk_count,
  input  logic                 tm_valid,
  output logic                 tm_ready,
  input  logic [TID_W-1:0]     tm_task,
  input  logic [PACK_W-1:0]    tm_count
);
  run_state_e           state_q;
  logic                 run;
  logic                 done_q;
  logic                 load;
  logic                 pick_any;
  logic [TID_W-1:0]     pick_idx;
  logic                 rpt_en;
  logic [NUM_TASKS-1:0] elig_v;
  logic [NUM_TASKS-1:0] long_v;
  logic [NUM_TASKS-1:0] rel_v;
  logic [NUM_TASKS-1:0] term_v;
  logic [NUM_TASKS-1:0] succ_m   [NUM_TASKS];
  logic [INST_W-1:0]    first_a  [NUM_TASKS];
  logic [PACK_W-1:0]    count_a  [NUM_TASKS];
  logic [DEP_W-1:0]     dec_a    [NUM_TASKS];
  logic                 pk_valid_q;
  logic [TID_W-1:0]     pk_task_q;
  logic [INST_W-1:0]    pk_first_q;
  logic [PACK_W-1:0]    pk_count_q;

  assign run      = (state_q == RUN_ACTIVE);
  assign busy     = run;
  assign done     = done_q;
  assign tm_ready = run;
  assign rpt_en   = tm_valid && run;
  assign load     = run && pick_any && (!pk_valid_q || pk_ready);

  genvar g;
  generate
    for (g = 0; g < NUM_TASKS; g++) begin : g_entry
      // Successor s loses one pending predecessor per releasing task naming it.
      always_comb begin
        dec_a[g] = '0;
        for (int t = 0; t < NUM_TASKS; t++) begin
          if (rel_v[t] && succ_m[t][g]) dec_a[g] = dec_a[g] + DEP_W'(1);
        end
      end

      tmsched_entry #(
        .NUM_TASKS(NUM_TASKS),
        .INST_W(INST_W),
        .DEP_W(DEP_W),
        .CAPACITY(CAPACITY),
        .ID(g)
      ) u_entry (
        .clk(clk),
        .rst_n(rst_n),
        .run(run),
        .start(start),
        .cfg_we(cfg_we),
        .cfg_task(cfg_task),
        .cfg_inst(cfg_inst),
        .cfg_deps(cfg_deps),
        .cfg_long(cfg_long),
        .cfg_succ(cfg_succ),
        .issue(load && (pick_idx == TID_W'(g))),
        .rpt_en(rpt_en),
        .rpt_task(tm_task),
        .rpt_count(tm_count),
        .dec_n(dec_a[g]),
        .eligible(elig_v[g]),
        .is_long(long_v[g]),
        .next_first(first_a[g]),
        .next_count(count_a[g]),
        .release_p(rel_v[g]),
        .succ(succ_m[g]),
        .terminal_ok(term_v[g])
      );
    end
  endgenerate

  tmsched_pick #(
    .NUM_TASKS(NUM_TASKS)
  ) u_pick (
    .elig(elig_v),
    .flag(long_v),
    .any(pick_any),
    .idx(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      done_q  <= 1'b0;
    end else if (!run) begin
      if (start) begin
        state_q <= RUN_ACTIVE;
        done_q  <= 1'b0;
      end
    end else if (&term_v) begin
      state_q <= RUN_IDLE;
      done_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk_valid_q <= 1'b0;
      pk_task_q  <= '0;
      pk_first_q <= '0;
      pk_count_q <= '0;
    end else if (load) begin
      pk_valid_q <= 1'b1;
      pk_task_q  <= pick_idx;
      pk_first_q <= first_a[pick_idx];
      pk_count_q <= count_a[pick_idx];
    end else if (pk_ready) begin
      pk_valid_q <= 1'b0;
    end
  end

  assign pk_valid = pk_valid_q;
  assign pk_task  = pk_task_q;
  assign pk_first = pk_first_q;
  assign pk_count = pk_count_q;
endmodule

// File: rtl/tmsched_chk.sv
module tmsched_chk #(
  parameter int unsigned NUM_TASKS = 8,
  parameter int unsigned INST_W = 10,
  parameter int unsigned CAPACITY = 5,
  localparam int unsigned TID_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int unsigned PACK_W = $clog2(CAPACITY + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 done,
  input logic                 pk_valid,
  input logic                 pk_ready,
  input logic [TID_W-1:0]     pk_task,
  input logic [INST_W-1:0]    pk_first,
  input logic [PACK_W-1:0]    pk_count,
  input logic                 load,
  input logic [NUM_TASKS-1:0] elig_v,
  input logic [NUM_TASKS-1:0] long_v
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_valid && !pk_ready) |=> (pk_valid && $stable(pk_task) && $stable(pk_first) && $stable(pk_count)));

  p_pack_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid |-> ((pk_count != '0) && (pk_count <= PACK_W'(CAPACITY))));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_long_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && |(elig_v & long_v)) |=> long_v[pk_task]);
endmodule

bind tmsched_top tmsched_chk #(
  .NUM_TASKS(NUM_TASKS),
  .INST_W(INST_W),
  .CAPACITY(CAPACITY)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .busy(busy),
  .done(done),
  .pk_valid(pk_valid),
  .pk_ready(pk_ready),
  .pk_task(pk_task),
  .pk_first(pk_first),
  .pk_count(pk_count),
  .load(load),
  .elig_v(elig_v),
  .long_v(long_v)
);

// File: tb/tmsched_top_tb.sv
`timescale 1ns/1ps
module tmsched_top_tb;
  localparam int NT = 8;
  localparam int IW = 10;
  localparam int DW = 4;
  localparam int CAP = 5;
  localparam int TW = 3;
  localparam int PW = $clog2(CAP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [TW-1:0] cfg_task = '0;
  logic [IW-1:0] cfg_inst = '0;
  logic [DW-1:0] cfg_deps = '0;
  logic cfg_long = 1'b0;
  logic [NT-1:0] cfg_succ = '0;
  logic start = 1'b0;
  logic busy, done, pk_valid, tm_ready;
  logic pk_ready = 1'b0;
  logic [TW-1:0] pk_task;
  logic [IW-1:0] pk_first;
  logic [PW-1:0] pk_count;
  logic tm_valid = 1'b0;
  logic [TW-1:0] tm_task = '0;
  logic [PW-1:0] tm_count = '0;

  always #5 clk = ~clk;

  tmsched_top #(.NUM_TASKS(NT), .INST_W(IW), .DEP_W(DW), .CAPACITY(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_task(cfg_task), .cfg_inst(cfg_inst),
    .cfg_deps(cfg_deps), .cfg_long(cfg_long), .cfg_succ(cfg_succ), .start(start),
    .busy(busy), .done(done), .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_task(pk_task),
    .pk_first(pk_first), .pk_count(pk_count), .tm_valid(tm_valid), .tm_ready(tm_ready),
    .tm_task(tm_task), .tm_count(tm_count));

  int n_chk = 0;
  int n_fail = 0;
  int m_inst [NT];
  bit m_long [NT];
  bit m_used [NT];
  bit [NT-1:0] m_succ [NT];
  int m_iss [NT];
  int m_fin [NT];
  int ot_task [512];
  int ot_rem [512];
  int ot_n;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic bit fin_ok(int t);
    return m_used[t] && (m_fin[t] == m_inst[t]);
  endfunction

  function automatic bit preds_ok(int t);
    for (int p = 0; p < NT; p++)
      if (m_used[p] && m_succ[p][t] && !fin_ok(p)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit terms_ok();
    for (int t = 0; t < NT; t++)
      if (m_used[t] && m_succ[t] == '0 && !fin_ok(t)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_pick();
    int best = -1;
    for (int t = NT - 1; t >= 0; t--)
      if (m_used[t] && m_iss[t] < m_inst[t] && preds_ok(t)) best = t;
    for (int t = NT - 1; t >= 0; t--)
      if (m_used[t] && m_long[t] && m_iss[t] < m_inst[t] && preds_ok(t)) best = t;
    return best;
  endfunction

  task automatic prog(input int t, input int inst, input int deps, input bit lng, input bit [NT-1:0] sc);
    @(negedge clk);
    cfg_we = 1'b1; cfg_task = TW'(t); cfg_inst = IW'(inst);
    cfg_deps = DW'(deps); cfg_long = lng; cfg_succ = sc;
    m_used[t] = 1'b1; m_inst[t] = inst; m_long[t] = lng; m_succ[t] = sc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_map(input bit prio_mode);
    bit held;
    logic [TW-1:0] h_task;
    logic [IW-1:0] h_first;
    logic [PW-1:0] h_count;
    int cyc;
    held = 1'b0;
    ot_n = 0;
    for (int t = 0; t < NT; t++) begin m_iss[t] = 0; m_fin[t] = 0; end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    chk(done === 1'b0, "R2/R8 done cleared by start", int'(done), 0);
    cyc = 0;
    while (cyc < 20000) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      cfg_we = 1'b0;
      if (!prio_mode && cyc == 3) begin
        cfg_we = 1'b1; cfg_task = '0; cfg_inst = IW'(m_inst[0] + 3); cfg_long = 1'b0;
      end
      if (held) begin
        chk(pk_valid === 1'b1, "R4 valid held", int'(pk_valid), 1);
        chk(pk_task === h_task && pk_first === h_first && pk_count === h_count,
            "R4 fields held", int'(pk_first), int'(h_first));
      end
      chk(tm_ready === busy, "R9 report ready follows busy", int'(tm_ready), int'(busy));
      chk(!(done === 1'b1 && !terms_ok()), "R8 done early", int'(done), 0);
      if (done === 1'b1) break;
      pk_ready = ($urandom % 4) != 0;
      if (pk_valid === 1'b1 && pk_ready) begin
        int t;
        int rem;
        int ep;
        t = int'(pk_task);
        rem = m_inst[t] - m_iss[t];
        ep = exp_pick();
        chk(m_used[t], "R10 unwritten entry dispatched", t, -1);
        chk(preds_ok(t), "R5/R6 dispatched before predecessors finished", t, -1);
        chk(int'(pk_first) == m_iss[t], "R3 first instance", int'(pk_first), m_iss[t]);
        chk(int'(pk_count) == ((rem > CAP) ? CAP : rem), "R3 pack size", int'(pk_count),
            (rem > CAP) ? CAP : rem);
        if (prio_mode) chk(t == ep, "R7 priority order", t, ep);
        m_iss[t] += int'(pk_count);
        ot_task[ot_n] = t; ot_rem[ot_n] = int'(pk_count); ot_n++;
      end
      held = (pk_valid === 1'b1) && !pk_ready;
      h_task = pk_task; h_first = pk_first; h_count = pk_count;
      tm_valid = 1'b0;
      if (tm_ready === 1'b1 && ot_n > 0 && ($urandom % 3) != 0) begin
        int k;
        int n;
        k = $urandom % ot_n;
        n = 1 + ($urandom % ot_rem[k]);
        tm_valid = 1'b1; tm_task = TW'(ot_task[k]); tm_count = PW'(n);
        m_fin[ot_task[k]] += n;
        ot_rem[k] -= n;
        if (ot_rem[k] == 0) begin
          ot_n--; ot_task[k] = ot_task[ot_n]; ot_rem[k] = ot_rem[ot_n];
        end
      end
    end
    tm_valid = 1'b0;
    pk_ready = 1'b0;
    chk(done === 1'b1, "R8 run finished", int'(done), 1);
    chk(busy === 1'b0, "R8 busy low at end", int'(busy), 0);
    for (int t = 0; t < NT; t++)
      if (m_used[t]) chk(m_iss[t] == m_inst[t], "R1/R3 total dispatched", m_iss[t], m_inst[t]);
  endtask

  initial begin
    int s;
    s = $urandom(32'd4242);
    repeat (20000 * 9) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    for (int t = 0; t < NT; t++) begin m_used[t] = 0; m_succ[t] = '0; m_inst[t] = 0; m_long[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R2 reset idle", int'(busy), 0);
    chk(pk_valid === 1'b0 && tm_ready === 1'b0, "R9 reset handshakes low", int'(pk_valid), 0);
    // R7 directed: independent tasks, two flagged; R10: entries 4..7 unwritten.
    prog(0, 7, 0, 1'b0, '0);
    prog(1, 3, 0, 1'b0, '0);
    prog(2, 12, 0, 1'b1, '0);
    prog(3, 4, 0, 1'b1, '0);
    run_map(1'b1);
    for (int r = 0; r < 4; r++) begin
      int dep [NT];
      bit [NT-1:0] sc [NT];
      for (int t = 0; t < NT; t++) dep[t] = 0;
      for (int t = 0; t < NT; t++) begin
        sc[t] = '0;
        for (int u = t + 1; u < NT; u++) if (($urandom % 3) == 0) sc[t][u] = 1'b1;
        if (t < NT - 1 && sc[t] == '0) sc[t][NT-1] = 1'b1;
        for (int u = 0; u < NT; u++) if (sc[t][u]) dep[u]++;
      end
      for (int t = 0; t < NT; t++)
        prog(t, (r == 0 && t == 1) ? CAP : 1 + ($urandom % 23), dep[t], ($urandom % 4) == 0, sc[t]);
      run_map(1'b0);
    end
    summary();
  end
endmodule